// File: doc/BRIEF.md
# Write Protect and Timed Write Cycle Unit

This unit sits behind the serial slave front end of a 256-byte nonvolatile store. When the front end sees a STOP that ends a write or protect command, it presents one commit request. The request carries a start address, a byte count of up to one page, the page payload, and a flag that marks the command as the one-shot lock command. The unit decides whether the commit may go ahead. If it may, the unit runs a timed internal write cycle and updates its own array when the cycle ends. The front end reads that array through a combinational read port.

Two protections decide each commit. The first is a lock flag that can be set only once and never cleared. After it is set, the lower half of the array (addresses 00h to 7Fh) can never be written again. The second is a write-protect pin that blocks every address. The unit samples the pin only inside a window. The window opens on the front end's strobe that reports the first data bit was clocked, and it closes at the end of the write cycle. If the pin rises during the cycle, the cycle stops at once. The bytes being written are then left with a fixed corrupt value and flagged as undefined. The cycle length is the parameter `WR_CYCLES`, counted in system clocks.

Top module: `wp_write_unit`

## Requirements
- R1: After reset every location reads FFh with its undefined flag clear, and `busy` and `done` are low.
- R2: A granted data commit writes `req_count` bytes (1 to 16). Byte i is taken from `req_data[8*i+7:8*i]` and goes to the address whose upper four bits equal those of `req_addr` and whose lower four bits are `req_addr[3:0]+i` modulo 16.
- R3: A granted commit raises `busy` in the cycle after it is accepted and keeps it high for exactly `WR_CYCLES` cycles. In the first cycle with `busy` low, `done` pulses for one cycle with `done_code` 0 (completed), and the array already holds the new bytes.
- R4: A commit request presented while `busy` is high is ignored and changes no location.
- R5: A commit accepted while `wp_pin` is high is refused. `done` pulses the next cycle with `done_code` 1 (refused), `busy` stays low and no location changes.
- R6: A `wp_pin` high level seen at or after the `d0_seen` strobe, before the commit, refuses that commit even if the pin is low at the commit. A high level that ends before the strobe has no effect.
- R7: If `wp_pin` is high in any cycle with `busy` high, `busy` is low in the next cycle and `done` pulses with `done_code` 2 (aborted). Each targeted byte then reads 00h with its undefined flag set, until a later completed write to that byte clears the flag.
- R8: A granted lock commit (`req_is_lock`=1) runs a full write cycle like a data commit and ends with code 0. From then on every data commit whose address has bit 7 clear is refused, while addresses 80h to FFh stay writable.
- R9: A lock commit issued after the lock is already set is refused with code 1 and starts no cycle.
- R10: While the lock is set, a lower-half data commit is refused whatever the level of `wp_pin`, and the locked bytes keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Commit request strobe from the front end (one cycle) |
| req_is_lock | input | 1 | 1: lock command, 0: data write |
| req_addr | input | 8 | Start address of the commit |
| req_count | input | 5 | Number of payload bytes, 1 to 16 |
| req_data | input | 128 | Page payload, byte i in bits 8*i+7:8*i |
| d0_seen | input | 1 | Strobe: first data bit of the first byte clocked in |
| wp_pin | input | 1 | Hardware write-protect level |
| rd_addr | input | 8 | Read port address |
| rd_data | output | 8 | Array contents at rd_addr |
| rd_undef | output | 1 | Undefined flag of the byte at rd_addr |
| busy | output | 1 | Internal write cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| done_code | output | 2 | 0 completed, 1 refused, 2 aborted |

## Verification
A wrong window flag or a stale lock flag would show at the ports in one of two ways. A commit might be refused or granted wrongly, which shows one cycle after the request as a wrong `done_code`. Or a byte read back after the operation might be wrong. A miscounted cycle timer would move the fall of `busy` away from exactly `WR_CYCLES` cycles after the request. A late abort would leave `busy` high one cycle after the pin rises. Wrong page address wrapping would only show on read-back, as a byte at the wrong in-page offset and an untouched byte where the wrapped write was due.

// File: rtl/wpu_pkg.sv
`timescale 1ns/1ps
package wpu_pkg;
    localparam int ADDR_W     = 8;
    localparam int PAGE_BYTES = 16;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int OFF_W      = $clog2(PAGE_BYTES);
    localparam int CNT_W      = $clog2(PAGE_BYTES + 1);
    localparam int DATA_W     = 8;
    localparam int PAYLOAD_W  = PAGE_BYTES * DATA_W;

    localparam logic [DATA_W-1:0] ERASED_VAL  = 8'hFF;
    localparam logic [DATA_W-1:0] CORRUPT_VAL = 8'h00;

    typedef enum logic [1:0] {
        DONE_OK      = 2'd0,
        DONE_REFUSED = 2'd1,
        DONE_ABORTED = 2'd2
    } done_code_e;

    typedef struct packed {
        logic                 is_lock;
        logic [ADDR_W-1:0]    addr;
        logic [CNT_W-1:0]     count;
        logic [PAYLOAD_W-1:0] data;
    } commit_t;

    // Address of slot idx inside the page that holds base; wraps in the page.
    function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base,
                                                    input logic [OFF_W-1:0]  idx);
        return {base[ADDR_W-1:OFF_W], base[OFF_W-1:0] + idx};
    endfunction
endpackage

// File: rtl/wpu_guard.sv
`timescale 1ns/1ps
module wpu_guard
    import wpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             d0_seen,
    input  logic             wp_pin,
    input  logic             accept,
    input  logic             set_lock,
    input  logic             is_lock,
    input  logic             addr_upper,
    input  logic [CNT_W-1:0] count,
    output logic             grant
);
    logic window_open;
    logic pin_tripped;
    logic lower_locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            window_open  <= 1'b0;
            pin_tripped  <= 1'b0;
            lower_locked <= 1'b0;
        end else begin
            if (accept) begin
                window_open <= 1'b0;
                pin_tripped <= 1'b0;
            end else if (d0_seen) begin
                window_open <= 1'b1;
                pin_tripped <= wp_pin;
            end else if (window_open && wp_pin) begin
                pin_tripped <= 1'b1;
            end
            if (set_lock) lower_locked <= 1'b1;
        end
    end

    logic lock_blocks;
    assign lock_blocks = lower_locked && (is_lock || !addr_upper);
    assign grant = !pin_tripped && !wp_pin && !lock_blocks
                   && (is_lock || count != '0);
endmodule

// File: rtl/wpu_timer.sv
`timescale 1ns/1ps
module wpu_timer #(
    parameter int CYCLES = 625000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic expire
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] remain;

    assign expire = busy && !abort && remain == '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= CW'(CYCLES - 1);
        end else if (abort || expire) begin
            busy   <= 1'b0;
        end else if (busy) begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/wpu_array.sv
`timescale 1ns/1ps
module wpu_array
    import wpu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 corrupt_en,
    input  logic [ADDR_W-1:0]    base,
    input  logic [CNT_W-1:0]     count,
    input  logic [PAYLOAD_W-1:0] data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_undef
);
    logic [DATA_W-1:0] cells [DEPTH];
    logic [DEPTH-1:0]  undef_map;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++) cells[a] <= ERASED_VAL;
            undef_map <= '0;
        end else if (wr_en || corrupt_en) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (CNT_W'(i) < count) begin
                    cells[slot_addr(base, OFF_W'(i))] <=
                        corrupt_en ? CORRUPT_VAL : data[DATA_W*i +: DATA_W];
                    undef_map[slot_addr(base, OFF_W'(i))] <= corrupt_en;
                end
            end
        end
    end

    assign rd_data  = cells[rd_addr];
    assign rd_undef = undef_map[rd_addr];
endmodule

// File: rtl/wp_write_unit.sv
`timescale 1ns/1ps
module wp_write_unit
    import wpu_pkg::*;
#(
    parameter int WR_CYCLES = 625000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_is_lock,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [CNT_W-1:0]     req_count,
    input  logic [PAYLOAD_W-1:0] req_data,
    input  logic                 d0_seen,
    input  logic                 wp_pin,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_undef,
    output logic                 busy,
    output logic                 done,
    output logic [1:0]           done_code
);
    commit_t held;
    logic    accept, grant, start, abort_now, expire;

    assign accept    = req_valid && !busy;
    assign start     = accept && grant;
    assign abort_now = busy && wp_pin;

    wpu_guard u_guard (
        .clk        (clk),
        .rst        (rst),
        .d0_seen    (d0_seen),
        .wp_pin     (wp_pin),
        .accept     (accept),
        .set_lock   (expire && held.is_lock),
        .is_lock    (req_is_lock),
        .addr_upper (req_addr[ADDR_W-1]),
        .count      (req_count),
        .grant      (grant)
    );

    wpu_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .abort  (abort_now),
        .busy   (busy),
        .expire (expire)
    );

    wpu_array u_array (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (expire && !held.is_lock),
        .corrupt_en (abort_now && !held.is_lock),
        .base       (held.addr),
        .count      (held.count),
        .data       (held.data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .rd_undef   (rd_undef)
    );

    done_code_e code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held   <= '0;
            done   <= 1'b0;
            code_q <= DONE_OK;
        end else begin
            if (start) held <= '{req_is_lock, req_addr, req_count, req_data};
            done <= 1'b0;
            if (accept && !grant) begin
                done   <= 1'b1;
                code_q <= DONE_REFUSED;
            end else if (abort_now) begin
                done   <= 1'b1;
                code_q <= DONE_ABORTED;
            end else if (expire) begin
                done   <= 1'b1;
                code_q <= DONE_OK;
            end
        end
    end

    assign done_code = code_q;
endmodule

// File: rtl/wpu_checker.sv
`timescale 1ns/1ps
module wpu_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       wp_pin,
    input logic       busy,
    input logic       done,
    input logic [1:0] done_code
);
    // R7: a pin high during the cycle ends it on the next edge with an abort code
    assert_abort_now_R7: assert property (@(posedge clk) disable iff (rst)
        busy && wp_pin |=> !busy && done && done_code == 2'd2);

    // R5: a cycle only starts from a request seen with the pin low
    assert_start_pin_low_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid && !wp_pin));

    // R3: completion is reported only once the cycle is over
    assert_done_idle_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R3: a completed code follows a running cycle
    assert_ok_after_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        done && done_code == 2'd0 |-> $past(busy));

    // R7: an abort code requires the pin high in the previous cycle
    assert_abort_cause_R7: assert property (@(posedge clk) disable iff (rst)
        done && done_code == 2'd2 |-> $past(wp_pin && busy));

    // R5: no reserved code value is ever reported
    assert_code_legal_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> done_code != 2'd3);
endmodule

bind wp_write_unit wpu_checker u_wpu_checker (.*);

// File: tb/tb_wp_write_unit.sv
`timescale 1ns/1ps
module tb_wp_write_unit;
    localparam int WR = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_is_lock = 1'b0;
    logic [7:0]   req_addr = '0;
    logic [4:0]   req_count = '0;
    logic [127:0] req_data = '0;
    logic         d0_seen = 1'b0;
    logic         wp_pin = 1'b0;
    logic [7:0]   rd_addr = '0;
    logic [7:0]   rd_data;
    logic         rd_undef;
    logic         busy, done;
    logic [1:0]   done_code;

    wp_write_unit #(.WR_CYCLES(WR)) dut (.*);

    always #4 clk = ~clk;

    int checks = 0, fails = 0, done_cnt = 0, busy_cycles = 0;
    bit finished = 0;
    logic [1:0] expq[$];
    string      tagq[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // Monitor: pops expected completion codes as done pulses appear
    always @(negedge clk) begin
        if (!rst && busy) busy_cycles++;
        if (!rst && done) begin
            done_cnt++;
            if (expq.size() == 0) check(0, "R4 unexpected done", done_code, 0);
            else begin
                automatic logic [1:0] e = expq.pop_front();
                automatic string t = tagq.pop_front();
                check(done_code == e, t, done_code, e);
            end
        end
    end

    task automatic issue(input bit lock, input logic [7:0] a, input int n,
                         input logic [127:0] d, input logic [1:0] exp, input string tag,
                         input bit expect_done = 1);
        @(negedge clk);
        req_is_lock = lock; req_addr = a; req_count = 5'(n); req_data = d;
        req_valid = 1'b1;
        if (expect_done) begin expq.push_back(exp); tagq.push_back(tag); end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (expq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic strobe_d0(input bit wp);
        @(negedge clk);
        wp_pin = wp; d0_seen = 1'b1;
        @(negedge clk);
        d0_seen = 1'b0;
    endtask

    task automatic read_chk(input logic [7:0] a, input logic [7:0] exp_d,
                            input bit exp_u, input string tag);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(rd_data == exp_d, tag, rd_data, exp_d);
        check(rd_undef == exp_u, {tag, " undef"}, rd_undef, exp_u);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        int b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
        read_chk(8'h10, 8'hFF, 0, "R1 erased");
        read_chk(8'hF7, 8'hFF, 0, "R1 erased hi");

        // R2/R3 page write wrapping inside the page, busy exactly WR cycles
        strobe_d0(0);
        b0 = busy_cycles;
        issue(0, 8'h9E, 3, 128'h00_0000_0000_0000_0000_0000_00C3_B2A1,
              2'd0, "R3 ok code");
        wait_done();
        check(busy_cycles - b0 == WR, "R3 busy length", busy_cycles - b0, WR);
        read_chk(8'h9E, 8'hA1, 0, "R2 slot0");
        read_chk(8'h9F, 8'hB2, 0, "R2 slot1");
        read_chk(8'h90, 8'hC3, 0, "R2 wrap slot2");
        read_chk(8'hA0, 8'hFF, 0, "R2 no spill");

        // R4 request during busy ignored
        strobe_d0(0);
        issue(0, 8'hC0, 1, 128'h55, 2'd0, "R4 first write");
        repeat (2) @(negedge clk);
        issue(0, 8'hB0, 1, 128'h66, 2'd0, "R4 ignored", 0);
        wait_done();
        read_chk(8'hC0, 8'h55, 0, "R4 first lands");
        read_chk(8'hB0, 8'hFF, 0, "R4 ignored write");

        // R5 pin high at commit
        strobe_d0(0);
        b0 = busy_cycles;
        @(negedge clk); wp_pin = 1'b1;
        issue(0, 8'h32, 1, 128'h11, 2'd1, "R5 refused");
        wait_done();
        wp_pin = 1'b0;
        check(busy_cycles == b0, "R5 no busy", busy_cycles - b0, 0);
        read_chk(8'h32, 8'hFF, 0, "R5 unchanged");

        // R6 pin pulse inside window refuses; pulse before strobe does not
        strobe_d0(0);
        @(negedge clk); wp_pin = 1'b1;
        @(negedge clk); wp_pin = 1'b0;
        issue(0, 8'h30, 1, 128'h22, 2'd1, "R6 window pulse");
        wait_done();
        read_chk(8'h30, 8'hFF, 0, "R6 unchanged");
        @(negedge clk); wp_pin = 1'b1;
        repeat (3) @(negedge clk);
        strobe_d0(0);
        issue(0, 8'h31, 1, 128'h3C, 2'd0, "R6 early pulse ignored");
        wait_done();
        read_chk(8'h31, 8'h3C, 0, "R6 written");

        // R7 abort mid-cycle
        strobe_d0(0);
        issue(0, 8'h40, 2, 128'h9988, 2'd2, "R7 abort code");
        repeat (3) @(negedge clk);
        wp_pin = 1'b1;
        @(negedge clk);
        check(busy == 0 && done == 1, "R7 immediate stop", {busy, done}, 1);
        wp_pin = 1'b0;
        wait_done();
        read_chk(8'h40, 8'h00, 1, "R7 corrupt0");
        read_chk(8'h41, 8'h00, 1, "R7 corrupt1");
        read_chk(8'h42, 8'hFF, 0, "R7 neighbour");
        strobe_d0(0);
        issue(0, 8'h40, 1, 128'h77, 2'd0, "R7 rewrite");
        wait_done();
        read_chk(8'h40, 8'h77, 0, "R7 flag cleared");

        // R8 lock command
        strobe_d0(0);
        issue(0, 8'h05, 1, 128'hA5, 2'd0, "R10 pre-lock write");
        wait_done();
        strobe_d0(0);
        b0 = busy_cycles;
        issue(1, 8'h00, 1, 128'h0, 2'd0, "R8 lock ok");
        wait_done();
        check(busy_cycles - b0 == WR, "R8 lock cycle", busy_cycles - b0, WR);
        strobe_d0(0);
        issue(0, 8'h85, 1, 128'h5A, 2'd0, "R8 upper ok");
        wait_done();
        read_chk(8'h85, 8'h5A, 0, "R8 upper written");

        // R9 second lock refused
        strobe_d0(0);
        b0 = busy_cycles;
        issue(1, 8'h00, 1, 128'h0, 2'd1, "R9 relock refused");
        wait_done();
        check(busy_cycles == b0, "R9 no cycle", busy_cycles - b0, 0);

        // R10 lower half refused with pin low; upper refused with pin high
        strobe_d0(0);
        issue(0, 8'h05, 1, 128'h12, 2'd1, "R10 locked write");
        wait_done();
        read_chk(8'h05, 8'hA5, 0, "R10 kept");
        strobe_d0(0);
        @(negedge clk); wp_pin = 1'b1;
        issue(0, 8'h86, 1, 128'h34, 2'd1, "R10 pin upper");
        wait_done();
        wp_pin = 1'b0;
        read_chk(8'h86, 8'hFF, 0, "R10 upper kept");

        check(expq.size() == 0, "R3 pending results", expq.size(), 0);
        summary();
    end
endmodule